// File: doc/BRIEF.md
# Load-Use Scoreboard with Early Completion

This block controls issue and completion for a short in-order pipeline with decode, execute, memory and writeback stages. A load goes from execute into the memory stage and then to writeback. A register-to-register ALU operation leaves execute and writes back on the next cycle, with no memory stage. An ALU operation that does not depend on an older load therefore retires before that load, so completion is out of order.

A scoreboard keeps one pending bit for each architectural register. The bit is set when a load is accepted from decode and cleared on the edge that ends the load's writeback cycle. Decode stalls only when the incoming operation has a real hazard:
- an enabled source register is still pending,
- its destination is still pending,
- it is a load and another load is still in execute or memory.

The memory stage holds its load until the memory-ready input is seen high. ALU operations behind the held load keep flowing. Load and ALU results each have their own writeback port, so both can retire in the same cycle.

Top module: `loaduse_ctrl`

## Requirements
- R1: After reset, stall, execute-valid, memory-valid and both writeback enables are low, and every pending bit is clear, so a valid operation with any registers is not stalled.
- R2: An ALU operation accepted on clock edge k raises ex_vld_o in the cycle after edge k. It raises alu_wb_en_o for exactly one cycle, the cycle after edge k+1, with alu_wb_reg_o equal to its destination.
- R3: A load accepted on edge k is in the memory stage (mem_vld_o high) after edge k+1. With mem_ready_i high, it raises ld_wb_en_o with its destination on ld_wb_reg_o in the cycle after edge k+2.
- R4: While mem_ready_i is low, the load stays in the memory stage and ld_wb_en_o stays low. On the edge after a cycle with the load present and mem_ready_i high, the load moves to writeback.
- R5: ALU operations accepted after a load that is held in memory write back on their normal schedule, ahead of that load.
- R6: A valid operation whose enabled source register (uop_src_a_en_i or uop_src_b_en_i high) has its pending bit set stalls. A source whose enable is low is ignored.
- R7: A valid operation whose destination register has its pending bit set stalls (write-after-write).
- R8: A load's pending bit stays set through its writeback cycle and clears on the following edge. A dependent operation waiting in decode is accepted on the edge after the load's writeback cycle.
- R9: A valid load stalls while another load is in execute or in the memory stage.
- R10: An ALU writeback and a load writeback that fall in the same cycle are both asserted in that cycle, each on its own port.
- R11: stall_o is low whenever uop_vld_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| uop_vld_i | input | 1 | Decoded operation present in decode |
| uop_load_i | input | 1 | 1 = load, 0 = ALU operation |
| uop_src_a_i | input | AW | First source register |
| uop_src_a_en_i | input | 1 | First source is read |
| uop_src_b_i | input | AW | Second source register |
| uop_src_b_en_i | input | 1 | Second source is read |
| uop_dst_i | input | AW | Destination register |
| mem_ready_i | input | 1 | Memory data available for the load in the memory stage |
| stall_o | output | 1 | Decode must hold the operation |
| ex_vld_o | output | 1 | Execute stage occupied |
| mem_vld_o | output | 1 | Memory stage occupied |
| alu_wb_en_o | output | 1 | ALU writeback port enable |
| alu_wb_reg_o | output | AW | ALU writeback register |
| ld_wb_en_o | output | 1 | Load writeback port enable |
| ld_wb_reg_o | output | AW | Load writeback register |

## Verification
The operation streams are built so that each one separates one effect:
- An isolated ALU operation, and a load followed by an independent ALU operation, fix the base latencies and the same-cycle dual writeback.
- A consumer issued one cycle after its load and one issued two cycles after it show the stall length tracking the load latency. That length must be three and two stall cycles.
- Holding memory-ready low with ALU operations queued behind the load shows early completion against a frozen memory stage.
- A disabled source naming the pending register must pass while the enabled one stalls, which tells the enable gating apart from a plain register compare.
- Back-to-back loads and a write-after-write pair each have to show their own stall count.

// File: rtl/loaduse_pkg.sv
package loaduse_pkg;
  typedef enum logic {
    OP_ALU  = 1'b0,
    OP_LOAD = 1'b1
  } op_kind_e;
endpackage

// File: rtl/loaduse_sb.sv
module loaduse_sb #(
  parameter int NREG = 16,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_en_i,
  input  logic [AW-1:0]   set_idx_i,
  input  logic            clr_en_i,
  input  logic [AW-1:0]   clr_idx_i,
  output logic [NREG-1:0] pend_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_bit
    logic set_hit, clr_hit;
    assign set_hit = set_en_i && (set_idx_i == AW'(r));
    assign clr_hit = clr_en_i && (clr_idx_i == AW'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      pend_o[r] <= 1'b0;
      else if (set_hit) pend_o[r] <= 1'b1;
      else if (clr_hit) pend_o[r] <= 1'b0;
    end
  end
endmodule

// File: rtl/loaduse_hazard.sv
module loaduse_hazard #(
  parameter int NREG = 16,
  localparam int AW = $clog2(NREG)
) (
  input  logic            vld_i,
  input  logic            is_load_i,
  input  logic [AW-1:0]   src_a_i,
  input  logic            src_a_en_i,
  input  logic [AW-1:0]   src_b_i,
  input  logic            src_b_en_i,
  input  logic [AW-1:0]   dst_i,
  input  logic [NREG-1:0] pend_i,
  input  logic            load_busy_i,
  output logic            stall_o
);
  logic raw_a, raw_b, waw, ld_struct;

  always_comb begin
    raw_a     = src_a_en_i && pend_i[src_a_i];
    raw_b     = src_b_en_i && pend_i[src_b_i];
    waw       = pend_i[dst_i];
    ld_struct = is_load_i && load_busy_i;
    stall_o   = vld_i && (raw_a || raw_b || waw || ld_struct);
  end
endmodule

// File: rtl/loaduse_stages.sv
module loaduse_stages
  import loaduse_pkg::*;
#(
  parameter int NREG = 16,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  op_kind_e      acc_kind_i,
  input  logic [AW-1:0] acc_dst_i,
  input  logic          mem_ready_i,
  output logic          ex_vld_o,
  output logic          mem_vld_o,
  output logic          alu_wb_en_o,
  output logic [AW-1:0] alu_wb_reg_o,
  output logic          ld_wb_en_o,
  output logic [AW-1:0] ld_wb_reg_o,
  output logic          load_busy_o
);
  op_kind_e      ex_kind;
  logic [AW-1:0] ex_dst, mem_dst;
  logic          ex_load, mem_done;

  assign ex_load     = ex_vld_o && (ex_kind == OP_LOAD);
  assign mem_done    = mem_vld_o && mem_ready_i;
  assign load_busy_o = ex_load || mem_vld_o;

  // execute
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_vld_o <= 1'b0;
      ex_kind  <= OP_ALU;
      ex_dst   <= '0;
    end else begin
      ex_vld_o <= acc_i;
      if (acc_i) begin
        ex_kind <= acc_kind_i;
        ex_dst  <= acc_dst_i;
      end
    end
  end

  // memory stage: holds the load until ready
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_vld_o <= 1'b0;
      mem_dst   <= '0;
    end else if (ex_load) begin
      mem_vld_o <= 1'b1;
      mem_dst   <= ex_dst;
    end else if (mem_done) begin
      mem_vld_o <= 1'b0;
    end
  end

  // two independent writeback ports
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alu_wb_en_o  <= 1'b0;
      alu_wb_reg_o <= '0;
      ld_wb_en_o   <= 1'b0;
      ld_wb_reg_o  <= '0;
    end else begin
      alu_wb_en_o <= ex_vld_o && !ex_load;
      if (ex_vld_o && !ex_load) alu_wb_reg_o <= ex_dst;
      ld_wb_en_o <= mem_done;
      if (mem_done) ld_wb_reg_o <= mem_dst;
    end
  end
endmodule

// File: rtl/loaduse_ctrl.sv
module loaduse_ctrl
  import loaduse_pkg::*;
#(
  parameter int NREG = 16,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          uop_vld_i,
  input  logic          uop_load_i,
  input  logic [AW-1:0] uop_src_a_i,
  input  logic          uop_src_a_en_i,
  input  logic [AW-1:0] uop_src_b_i,
  input  logic          uop_src_b_en_i,
  input  logic [AW-1:0] uop_dst_i,
  input  logic          mem_ready_i,
  output logic          stall_o,
  output logic          ex_vld_o,
  output logic          mem_vld_o,
  output logic          alu_wb_en_o,
  output logic [AW-1:0] alu_wb_reg_o,
  output logic          ld_wb_en_o,
  output logic [AW-1:0] ld_wb_reg_o
);
  logic [NREG-1:0] pend;
  logic            load_busy, acc;
  op_kind_e        kind;

  assign kind = uop_load_i ? OP_LOAD : OP_ALU;
  assign acc  = uop_vld_i && !stall_o;

  loaduse_hazard #(.NREG(NREG)) u_haz (
    .vld_i      (uop_vld_i),
    .is_load_i  (uop_load_i),
    .src_a_i    (uop_src_a_i),
    .src_a_en_i (uop_src_a_en_i),
    .src_b_i    (uop_src_b_i),
    .src_b_en_i (uop_src_b_en_i),
    .dst_i      (uop_dst_i),
    .pend_i     (pend),
    .load_busy_i(load_busy),
    .stall_o    (stall_o)
  );

  loaduse_sb #(.NREG(NREG)) u_sb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (acc && uop_load_i),
    .set_idx_i(uop_dst_i),
    .clr_en_i (ld_wb_en_o),
    .clr_idx_i(ld_wb_reg_o),
    .pend_o   (pend)
  );

  loaduse_stages #(.NREG(NREG)) u_stg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .acc_kind_i  (kind),
    .acc_dst_i   (uop_dst_i),
    .mem_ready_i (mem_ready_i),
    .ex_vld_o    (ex_vld_o),
    .mem_vld_o   (mem_vld_o),
    .alu_wb_en_o (alu_wb_en_o),
    .alu_wb_reg_o(alu_wb_reg_o),
    .ld_wb_en_o  (ld_wb_en_o),
    .ld_wb_reg_o (ld_wb_reg_o),
    .load_busy_o (load_busy)
  );
endmodule

// File: rtl/loaduse_ctrl_chk.sv
module loaduse_ctrl_chk #(
  parameter int NREG = 16,
  localparam int AW = $clog2(NREG)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          uop_vld_i,
  input logic          uop_load_i,
  input logic [AW-1:0] uop_src_a_i,
  input logic          uop_src_a_en_i,
  input logic [AW-1:0] uop_dst_i,
  input logic          mem_ready_i,
  input logic          stall_o,
  input logic          ex_vld_o,
  input logic          mem_vld_o,
  input logic          alu_wb_en_o,
  input logic [AW-1:0] alu_wb_reg_o,
  input logic          ld_wb_en_o,
  input logic [AW-1:0] ld_wb_reg_o
);
  logic acc_alu;
  assign acc_alu = uop_vld_i && !stall_o && !uop_load_i;

  a_r11_stall_needs_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> uop_vld_i);

  a_r2_alu_enters_ex: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_alu |=> ex_vld_o);

  a_r2_alu_wb_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_alu |-> ##2 (alu_wb_en_o && alu_wb_reg_o == $past(uop_dst_i, 2)));

  a_r3_mem_to_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_vld_o && mem_ready_i) |=> ld_wb_en_o);

  a_r4_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_vld_o && !mem_ready_i) |=> (mem_vld_o && !ld_wb_en_o));

  a_r9_one_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_vld_i && uop_load_i && mem_vld_o) |-> stall_o);

  a_r8_pend_through_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_vld_i && uop_src_a_en_i && ld_wb_en_o && ld_wb_reg_o == uop_src_a_i) |-> stall_o);
endmodule

bind loaduse_ctrl loaduse_ctrl_chk #(.NREG(NREG)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .uop_vld_i     (uop_vld_i),
  .uop_load_i    (uop_load_i),
  .uop_src_a_i   (uop_src_a_i),
  .uop_src_a_en_i(uop_src_a_en_i),
  .uop_dst_i     (uop_dst_i),
  .mem_ready_i   (mem_ready_i),
  .stall_o       (stall_o),
  .ex_vld_o      (ex_vld_o),
  .mem_vld_o     (mem_vld_o),
  .alu_wb_en_o   (alu_wb_en_o),
  .alu_wb_reg_o  (alu_wb_reg_o),
  .ld_wb_en_o    (ld_wb_en_o),
  .ld_wb_reg_o   (ld_wb_reg_o)
);

// File: tb/sim_loaduse_ctrl.sv
`timescale 1ns/1ps
module sim_loaduse_ctrl;
  localparam int NREG = 16;
  localparam int AW = $clog2(NREG);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          uop_vld = 1'b0, uop_load = 1'b0, a_en = 1'b0, b_en = 1'b0;
  logic [AW-1:0] src_a = '0, src_b = '0, dst = '0;
  logic          mem_ready = 1'b1;
  logic          stall_o, ex_vld_o, mem_vld_o, alu_wb_en_o, ld_wb_en_o;
  logic [AW-1:0] alu_wb_reg_o, ld_wb_reg_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int    rg;
    int    cy;
    string req;
  } exp_t;
  exp_t alu_q[$];
  exp_t ld_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  loaduse_ctrl #(.NREG(NREG)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .uop_vld_i(uop_vld), .uop_load_i(uop_load),
    .uop_src_a_i(src_a), .uop_src_a_en_i(a_en),
    .uop_src_b_i(src_b), .uop_src_b_en_i(b_en),
    .uop_dst_i(dst), .mem_ready_i(mem_ready),
    .stall_o(stall_o), .ex_vld_o(ex_vld_o), .mem_vld_o(mem_vld_o),
    .alu_wb_en_o(alu_wb_en_o), .alu_wb_reg_o(alu_wb_reg_o),
    .ld_wb_en_o(ld_wb_en_o), .ld_wb_reg_o(ld_wb_reg_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one op from a negedge; returns on the negedge after acceptance
  task automatic send(input bit ld, input int a, input bit ae, input int b,
                      input bit be, input int d, input int exp_stalls,
                      input int ld_extra, input string req);
    int n = 0;
    uop_vld = 1'b1; uop_load = ld;
    src_a = AW'(a); a_en = ae; src_b = AW'(b); b_en = be; dst = AW'(d);
    #1;
    while (stall_o) begin
      n++;
      @(negedge clk); #1;
    end
    chk(n == exp_stalls, req, "stall cycles", n, exp_stalls);
    if (ld) ld_q.push_back('{d, cyc + 3 + ld_extra, req});
    else    alu_q.push_back('{d, cyc + 2, req});
    @(negedge clk);
    uop_vld = 1'b0; a_en = 1'b0; b_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected writebacks per port
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_ni && !done) begin
      if (alu_wb_en_o) begin
        if (alu_q.size() == 0) chk(1'b0, "R2", "unexpected alu wb", 1, 0);
        else begin
          e = alu_q.pop_front();
          chk(int'(alu_wb_reg_o) == e.rg, e.req, "alu wb reg", int'(alu_wb_reg_o), e.rg);
          chk(cyc == e.cy, e.req, "alu wb cycle", cyc, e.cy);
        end
      end
      if (ld_wb_en_o) begin
        if (ld_q.size() == 0) chk(1'b0, "R3", "unexpected load wb", 1, 0);
        else begin
          e = ld_q.pop_front();
          chk(int'(ld_wb_reg_o) == e.rg, e.req, "load wb reg", int'(ld_wb_reg_o), e.rg);
          chk(cyc == e.cy, e.req, "load wb cycle", cyc, e.cy);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset, nothing pending
    chk(!ex_vld_o && !mem_vld_o && !alu_wb_en_o && !ld_wb_en_o, "R1", "stage valids",
        int'(ex_vld_o) + int'(mem_vld_o) + int'(alu_wb_en_o) + int'(ld_wb_en_o), 0);
    uop_vld = 1'b1; uop_load = 1'b1; src_a = 4'd9; a_en = 1'b1;
    src_b = 4'd10; b_en = 1'b1; dst = 4'd11;
    #1;
    chk(!stall_o, "R1", "stall with empty scoreboard", int'(stall_o), 0);
    uop_vld = 1'b0; a_en = 1'b0; b_en = 1'b0;
    @(negedge clk);

    // R2: lone ALU op
    send(0, 1, 1, 2, 1, 3, 0, 0, "R2");
    idle(4);

    // R10 / R8: load, independent ALU (same-cycle wb), consumer 2 after load
    send(1, 0, 0, 0, 0, 5, 0, 0, "R3");
    send(0, 1, 1, 2, 1, 6, 0, 0, "R10");
    send(0, 5, 1, 2, 1, 4, 2, 0, "R8");
    idle(5);

    // R6: consumer right behind its load
    send(1, 0, 0, 0, 0, 5, 0, 0, "R3");
    send(0, 3, 1, 5, 1, 7, 3, 0, "R6");
    idle(5);

    // R4 / R5: memory held, ALU ops complete early
    mem_ready = 1'b0;
    send(1, 0, 0, 0, 0, 7, 0, 4, "R4");
    send(0, 1, 1, 2, 1, 8, 0, 0, "R5");
    send(0, 2, 1, 3, 1, 9, 0, 0, "R5");
    send(0, 8, 1, 9, 0, 10, 0, 0, "R5");
    idle(2);
    chk(mem_vld_o && !ld_wb_en_o, "R4", "load held in memory",
        int'(mem_vld_o) * 2 + int'(ld_wb_en_o), 2);
    mem_ready = 1'b1;
    idle(6);

    // R7: write-after-write on a pending load destination
    send(1, 0, 0, 0, 0, 11, 0, 0, "R3");
    send(0, 1, 1, 2, 1, 11, 3, 0, "R7");
    idle(5);

    // R6: disabled source naming a pending reg is ignored, enabled one stalls
    send(1, 0, 0, 0, 0, 12, 0, 0, "R3");
    send(0, 1, 1, 12, 0, 13, 0, 0, "R6");
    send(0, 1, 0, 12, 1, 14, 2, 0, "R6");
    idle(5);

    // R9: back-to-back loads
    send(1, 0, 0, 0, 0, 13, 0, 0, "R3");
    send(1, 0, 0, 0, 0, 14, 2, 0, "R9");
    idle(6);

    // R11 / R3: invalid op never stalls; load occupies execute then memory
    send(1, 0, 0, 0, 0, 15, 0, 0, "R3");
    chk(ex_vld_o, "R3", "load in execute", int'(ex_vld_o), 1);
    src_a = 4'd15; a_en = 1'b1; uop_vld = 1'b0;
    #1;
    chk(!stall_o, "R11", "stall without valid", int'(stall_o), 0);
    @(negedge clk);
    chk(mem_vld_o, "R3", "load in memory", int'(mem_vld_o), 1);
    a_en = 1'b0;
    idle(6);

    chk(alu_q.size() == 0, "R2", "alu wb outstanding", alu_q.size(), 0);
    chk(ld_q.size() == 0, "R3", "load wb outstanding", ld_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule